// File: doc/BRIEF.md
# Vectored Interrupt Request Controller

This block gathers interrupt requests from three sources: one external pin and two timer overflow strobes. Each request is caught in a sticky flag, masked by a per-source enable bit and by a global enable, and folded into one request line to the processor. Every source uses the same vector address. Software decides priority by polling the flags inside one shared service routine. Software also clears each flag itself, because taking the vector does not touch the flags.

The external pin first passes through a synchronizer. An edge detector then follows it, and a two-bit field chooses which edge it reacts to: rising, falling or both. While the system is powered down, a matching edge on the pin raises a wake output and sets the pin's flag. Both stay set, so the request is still pending after wake-up. A one-level shadow store keeps the accumulator and the flag byte for the save and restore instructions. The two reset-status bits of the flag byte are not saved and always pass straight through from the live value. A small register bus gives access to the flags, the enables, the edge field and the global enable.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, the request, enable, edge-select and control registers all read 0x00, `irq_req` is 0 and `wake_req` is 0.
- R2: A one-cycle high on `tmr0_ovf` or `tmr1_ovf` sets bit 4 or bit 5 of the request register (bus address 0). The new value is visible after the next rising clock edge.
- R3: The edge field is bits [1:0] at bus address 2. Its codes are 01 = rising edge only, 10 = falling edge only, 11 = both edges, and 00 = falling edge. A matching change on `ext_pin` sets request bit 0 on the third rising clock edge after the change. A change that does not match leaves the bit clear.
- R4: Request flags are cleared only by software. A bus write to address 0 loads bits 0, 4 and 5 from the write data, so a 0 clears a flag and a 1 sets it. `irq_ack` leaves the flags unchanged.
- R5: If a hardware request and a software clear of the same flag fall in the same cycle, the flag ends up set.
- R6: The enable register (address 1) uses bits 0, 4 and 5, the same positions as the request register. `irq_req` is 1 exactly when the global enable (bit 0 at address 3) is 1 and at least one flag has its enable bit set. `vec_addr` always shows 0x008.
- R7: `irq_ack` clears the global enable, and `irq_req` is 0 in the next cycle. If `irq_ack` comes in the same cycle as a bus write or a return, the clear wins. `irq_ret` sets the global enable.
- R8: While `sleep` is 1, a pin edge that matches the edge field sets `wake_req` together with request bit 0. `wake_req` stays 1 until `sleep` goes low. The flag stays set after wake-up.
- R9: `push` captures `acc_in` and `flags_in`. `acc_out` then shows the saved accumulator. `flags_out` bits [5:0] show the saved flags, and bits [7:6] always follow the live `flags_in`. Without `push`, the saved values do not change.
- R10: Register bits with no function read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_pin | input | 1 | External interrupt pin, asynchronous |
| tmr0_ovf | input | 1 | First timer overflow strobe |
| tmr1_ovf | input | 1 | Second timer overflow strobe |
| sleep | input | 1 | High while the system is powered down |
| bus_addr | input | 2 | Register select: 0 request, 1 enable, 2 edge, 3 control |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Read data of the selected register |
| irq_req | output | 1 | Vector request to the processor |
| irq_ack | input | 1 | Processor takes the vector |
| irq_ret | input | 1 | Processor returns from the service routine |
| vec_addr | output | 10 | Shared vector address |
| wake_req | output | 1 | Wake request raised by the pin during power-down |
| push | input | 1 | Save accumulator and flags |
| acc_in | input | 8 | Live accumulator |
| flags_in | input | 8 | Live flag byte |
| acc_out | output | 8 | Saved accumulator |
| flags_out | output | 8 | Restored flag byte |

## Verification
A flag stuck at zero, or a wrong bit position, shows up in the next read of address 0 and in an `irq_req` that stays low. Either is visible one cycle after a timer strobe, or three cycles after a pin edge. A wrong polarity decode shows as a flag that is set or left clear against the edge code, on the third clock after the pin moves. A global enable that is not cleared keeps `irq_req` high in the cycle after `irq_ack`. A shadow store that overwrites or leaks the status bits shows up on `acc_out` and `flags_out` as soon as the live inputs change.

// File: rtl/irq_vc_pkg.sv
package irq_vc_pkg;
   localparam int NSRC    = 3;
   localparam int DW      = 8;
   localparam int BIT_EXT = 0;
   localparam int BIT_T0  = 4;
   localparam int BIT_T1  = 5;

   typedef enum logic [1:0] {
      RA_REQ  = 2'd0,
      RA_EN   = 2'd1,
      RA_EDGE = 2'd2,
      RA_CTRL = 2'd3
   } reg_addr_e;

   typedef enum logic [1:0] {
      EDG_DFLT = 2'b00,
      EDG_RISE = 2'b01,
      EDG_FALL = 2'b10,
      EDG_BOTH = 2'b11
   } edge_sel_e;

   function automatic int src_bit(input int idx);
      case (idx)
         0:       return BIT_EXT;
         1:       return BIT_T0;
         default: return BIT_T1;
      endcase
   endfunction
endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pin,
   input  logic [1:0] sel,
   output logic       hit
);
   import irq_vc_pkg::*;

   localparam int CHAIN = SYNC_STAGES + 1;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("irq_edge_det: SYNC_STAGES must be at least 2");
   end

   logic [CHAIN-1:0] sh;
   logic             cur, prev, rise, fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '0;
      else        sh <= {sh[CHAIN-2:0], pin};
   end

   assign cur  = sh[SYNC_STAGES-1];
   assign prev = sh[SYNC_STAGES];
   assign rise = cur & ~prev;
   assign fall = ~cur & prev;

   always_comb begin
      case (edge_sel_e'(sel))
         EDG_RISE: hit = rise;
         EDG_BOTH: hit = rise | fall;
         default:  hit = fall;
      endcase
   end

   AST_EDGE_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> (cur != prev)); // R3
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
   parameter int DW   = 8,
   parameter int NSRC = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] set,
   input  logic            wr_req,
   input  logic            wr_en,
   input  logic [DW-1:0]   wdata,
   output logic [DW-1:0]   req_vec,
   output logic [DW-1:0]   en_vec,
   output logic            pend
);
   import irq_vc_pkg::*;

   logic [NSRC-1:0] flag, ena;

   for (genvar i = 0; i < NSRC; i++) begin : g_src
      localparam int B = src_bit(i);

      if (B >= DW) begin : g_bad_bit
         $error("irq_flag_bank: source bit outside data width");
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      flag[i] <= 1'b0;
         else if (set[i]) flag[i] <= 1'b1;
         else if (wr_req) flag[i] <= wdata[B];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     ena[i] <= 1'b0;
         else if (wr_en) ena[i] <= wdata[B];
      end

      AST_HW_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
         set[i] |=> req_vec[B]); // R5
      AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
         (req_vec[B] && !wr_req) |=> req_vec[B]); // R4
   end

   always_comb begin
      req_vec = '0;
      en_vec  = '0;
      for (int i = 0; i < NSRC; i++) begin
         req_vec[src_bit(i)] = flag[i];
         en_vec[src_bit(i)]  = ena[i];
      end
   end

   assign pend = |(flag & ena);
endmodule

// File: rtl/irq_shadow.sv
module irq_shadow #(
   parameter int          DW        = 8,
   parameter logic [7:0]  KEEP_MASK = 8'h3F
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [DW-1:0] acc_in,
   input  logic [DW-1:0] flg_in,
   output logic [DW-1:0] acc_out,
   output logic [DW-1:0] flg_out
);
   localparam logic [DW-1:0] MASK = DW'(KEEP_MASK);

   if (DW < 8) begin : g_bad_dw
      $error("irq_shadow: DW must be at least 8");
   end

   logic [DW-1:0] sv_acc, sv_flg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sv_acc <= '0;
         sv_flg <= '0;
      end else if (push) begin
         sv_acc <= acc_in;
         sv_flg <= flg_in & MASK;
      end
   end

   assign acc_out = sv_acc;
   assign flg_out = (flg_in & ~MASK) | (sv_flg & MASK);

   AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !push |=> $stable(acc_out)); // R9
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
   parameter int          ADDR_W      = 10,
   parameter logic [15:0] VEC_ADDR    = 16'h0008,
   parameter int          SYNC_STAGES = 2,
   parameter logic [7:0]  KEEP_MASK   = 8'h3F
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ext_pin,
   input  logic               tmr0_ovf,
   input  logic               tmr1_ovf,
   input  logic               sleep,
   input  logic [1:0]         bus_addr,
   input  logic               bus_wr,
   input  logic [7:0]         bus_wdata,
   output logic [7:0]         bus_rdata,
   output logic               irq_req,
   input  logic               irq_ack,
   input  logic               irq_ret,
   output logic [ADDR_W-1:0]  vec_addr,
   output logic               wake_req,
   input  logic               push,
   input  logic [7:0]         acc_in,
   input  logic [7:0]         flags_in,
   output logic [7:0]         acc_out,
   output logic [7:0]         flags_out
);
   import irq_vc_pkg::*;

   if (ADDR_W < 4 || ADDR_W > 16) begin : g_bad_aw
      $error("irq_vector_ctrl: ADDR_W out of range");
   end

   logic [1:0]    edge_sel;
   logic          gie, wake_r, ext_hit, pend;
   logic [DW-1:0] req_vec, en_vec;
   logic          wr_req, wr_en, wr_edge, wr_ctrl;

   assign wr_req  = bus_wr && (reg_addr_e'(bus_addr) == RA_REQ);
   assign wr_en   = bus_wr && (reg_addr_e'(bus_addr) == RA_EN);
   assign wr_edge = bus_wr && (reg_addr_e'(bus_addr) == RA_EDGE);
   assign wr_ctrl = bus_wr && (reg_addr_e'(bus_addr) == RA_CTRL);

   irq_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk(clk), .rst_n(rst_n), .pin(ext_pin), .sel(edge_sel), .hit(ext_hit)
   );

   irq_flag_bank #(.DW(DW), .NSRC(NSRC)) u_flags (
      .clk(clk), .rst_n(rst_n),
      .set({tmr1_ovf, tmr0_ovf, ext_hit}),
      .wr_req(wr_req), .wr_en(wr_en), .wdata(bus_wdata),
      .req_vec(req_vec), .en_vec(en_vec), .pend(pend)
   );

   irq_shadow #(.DW(DW), .KEEP_MASK(KEEP_MASK)) u_shadow (
      .clk(clk), .rst_n(rst_n), .push(push),
      .acc_in(acc_in), .flg_in(flags_in),
      .acc_out(acc_out), .flg_out(flags_out)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       edge_sel <= 2'b00;
      else if (wr_edge) edge_sel <= bus_wdata[1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       gie <= 1'b0;
      else if (irq_ack) gie <= 1'b0;
      else if (wr_ctrl) gie <= bus_wdata[0];
      else if (irq_ret) gie <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     wake_r <= 1'b0;
      else if (sleep) wake_r <= wake_r | ext_hit;
      else            wake_r <= 1'b0;
   end

   always_comb begin
      case (reg_addr_e'(bus_addr))
         RA_REQ:  bus_rdata = req_vec;
         RA_EN:   bus_rdata = en_vec;
         RA_EDGE: bus_rdata = {6'b0, edge_sel};
         default: bus_rdata = {7'b0, gie};
      endcase
   end

   assign irq_req  = gie & pend;
   assign wake_req = wake_r;
   assign vec_addr = VEC_ADDR[ADDR_W-1:0];

   AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      irq_ack |=> !irq_req); // R7
   AST_WAKE_IN_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wake_req) |-> $past(sleep)); // R8
   AST_WAKE_FLAGS_PIN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wake_req) |-> req_vec[BIT_EXT]); // R8
endmodule

// File: tb/irq_vector_ctrl_tb.sv
module irq_vector_ctrl_tb;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ext_pin = 1'b0, tmr0_ovf = 1'b0, tmr1_ovf = 1'b0, sleep = 1'b0;
   logic [1:0] bus_addr = 2'd0;
   logic       bus_wr = 1'b0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic       irq_req, irq_ack = 1'b0, irq_ret = 1'b0;
   logic [9:0] vec_addr;
   logic       wake_req, push = 1'b0;
   logic [7:0] acc_in = 8'h00, flags_in = 8'h00, acc_out, flags_out;

   int n_tests = 0, n_fail = 0;
   bit done = 1'b0;

   int     q_sel[$];
   int     q_exp[$];
   string  q_tag[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_vector_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .tmr0_ovf(tmr0_ovf),
      .tmr1_ovf(tmr1_ovf), .sleep(sleep), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_req(irq_req),
      .irq_ack(irq_ack), .irq_ret(irq_ret), .vec_addr(vec_addr),
      .wake_req(wake_req), .push(push), .acc_in(acc_in), .flags_in(flags_in),
      .acc_out(acc_out), .flags_out(flags_out)
   );

   function automatic int observe(input int sel);
      case (sel)
         0: return int'(bus_rdata);
         1: return int'(irq_req);
         2: return int'(wake_req);
         3: return int'(acc_out);
         4: return int'(flags_out);
         default: return int'(vec_addr);
      endcase
   endfunction

   // monitor: pops expected items and compares at the falling edge
   always @(negedge clk) begin
      while (q_sel.size() > 0) begin
         int    s, e, a;
         string t;
         s = q_sel.pop_front();
         e = q_exp.pop_front();
         t = q_tag.pop_front();
         a = observe(s);
         n_tests++;
         if (a !== e) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", t, a, e);
         end
      end
   end

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic expect_out(input int sel, input int exp, input string tag);
      q_sel.push_back(sel);
      q_exp.push_back(exp);
      q_tag.push_back(tag);
      @(negedge clk);
      #1;
   endtask

   task automatic expect_reg(input logic [1:0] a, input int exp, input string tag);
      bus_addr = a;
      expect_out(0, exp, tag);
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      tick();
      bus_wr = 1'b0;
   endtask

   task automatic pin_move(input logic v);
      ext_pin = v;
      repeat (3) tick();
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD*2 + 1);
      expect_reg(2'd0, 8'h00, "R1 request reset");
      rst_n = 1'b1;
      tick();
      expect_reg(2'd0, 8'h00, "R1 request after reset");
      expect_reg(2'd1, 8'h00, "R1 enable after reset");
      expect_reg(2'd2, 8'h00, "R1 edge after reset");
      expect_reg(2'd3, 8'h00, "R1 control after reset");
      expect_out(1, 0, "R1 irq_req after reset");
      expect_out(2, 0, "R1 wake_req after reset");
      expect_out(5, 10'h008, "R6 vector address");

      // R2 timers
      tmr0_ovf = 1'b1; tick(); tmr0_ovf = 1'b0;
      expect_reg(2'd0, 8'h10, "R2 timer0 flag");
      tmr1_ovf = 1'b1; tick(); tmr1_ovf = 1'b0;
      expect_reg(2'd0, 8'h30, "R2 timer1 flag");
      wr(2'd0, 8'h00);
      expect_reg(2'd0, 8'h00, "R4 software clear");
      wr(2'd0, 8'hFF);
      expect_reg(2'd0, 8'h31, "R10 only functional bits set");
      wr(2'd0, 8'h00);

      // R3 polarity
      wr(2'd2, 8'h01);
      expect_reg(2'd2, 8'h01, "R3 edge field readback");
      ext_pin = 1'b1; repeat (2) tick();
      expect_reg(2'd0, 8'h00, "R3 not yet after two clocks");
      tick();
      expect_reg(2'd0, 8'h01, "R3 rising code 01 sets");
      wr(2'd0, 8'h00);
      pin_move(1'b0); tick();
      expect_reg(2'd0, 8'h00, "R3 rising code ignores fall");
      wr(2'd2, 8'h02);
      pin_move(1'b1); tick();
      expect_reg(2'd0, 8'h00, "R3 falling code ignores rise");
      pin_move(1'b0);
      expect_reg(2'd0, 8'h01, "R3 falling code 10 sets");
      wr(2'd0, 8'h00);
      wr(2'd2, 8'h03);
      pin_move(1'b1);
      expect_reg(2'd0, 8'h01, "R3 both code rise");
      wr(2'd0, 8'h00);
      pin_move(1'b0);
      expect_reg(2'd0, 8'h01, "R3 both code fall");
      wr(2'd0, 8'h00);
      wr(2'd2, 8'h00);
      pin_move(1'b1); tick();
      expect_reg(2'd0, 8'h00, "R3 code 00 ignores rise");
      pin_move(1'b0);
      expect_reg(2'd0, 8'h01, "R3 code 00 acts as falling");
      wr(2'd0, 8'h00);

      // R5 set wins over clear
      tmr1_ovf = 1'b1;
      wr(2'd0, 8'h00);
      tmr1_ovf = 1'b0;
      expect_reg(2'd0, 8'h20, "R5 hardware set beats clear");

      // R6 / R7 gating
      wr(2'd1, 8'h31);
      expect_reg(2'd1, 8'h31, "R6 enable positions");
      expect_out(1, 0, "R6 no request without global enable");
      wr(2'd3, 8'h01);
      expect_out(1, 1, "R6 request with enable and flag");
      wr(2'd1, 8'h01);
      expect_out(1, 0, "R6 masked source gives no request");
      wr(2'd1, 8'h20);
      expect_out(1, 1, "R6 bit5 enable");
      irq_ack = 1'b1; tick(); irq_ack = 1'b0;
      expect_out(1, 0, "R7 ack drops request");
      expect_reg(2'd0, 8'h20, "R4 ack leaves flag");
      expect_reg(2'd3, 8'h00, "R7 ack clears global enable");
      irq_ret = 1'b1; tick(); irq_ret = 1'b0;
      expect_out(1, 1, "R7 return restores request");
      bus_addr = 2'd3; bus_wdata = 8'h01; bus_wr = 1'b1; irq_ack = 1'b1;
      tick();
      bus_wr = 1'b0; irq_ack = 1'b0;
      expect_reg(2'd3, 8'h00, "R7 ack wins over write");
      wr(2'd0, 8'h00);

      // R8 wake
      wr(2'd2, 8'h02);
      pin_move(1'b1); tick();
      sleep = 1'b1;
      tick();
      expect_out(2, 0, "R8 no wake without edge");
      pin_move(1'b0);
      expect_out(2, 1, "R8 wake on falling edge in sleep");
      expect_reg(2'd0, 8'h01, "R8 pin flag set with wake");
      tick();
      expect_out(2, 1, "R8 wake held");
      sleep = 1'b0; tick();
      expect_out(2, 0, "R8 wake released");
      expect_reg(2'd0, 8'h01, "R8 flag kept after wake");

      // R9 shadow
      acc_in = 8'h5A; flags_in = 8'hC7; push = 1'b1; tick(); push = 1'b0;
      acc_in = 8'h00; flags_in = 8'h80; tick();
      expect_out(3, 8'h5A, "R9 saved accumulator");
      expect_out(4, 8'h87, "R9 flags merge status bits");
      flags_in = 8'h40;
      expect_out(4, 8'h47, "R9 status bits follow live value");

      done = 1'b1;
      @(negedge clk);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule